// File: doc/BRIEF.md
# ADC Conversion-Start and Power-Mode Sequencer

This block holds the digital timing and control of a 10-bit sampling converter that has a single convert-start input. A rising edge on that input starts a fixed power-up window. The window is ORed with the start input itself, and a conversion begins when that combined signal goes low. The conversion begins when the window has run out and the start input is low, whichever comes later. While the conversion runs, a busy output is high. When busy drops, the held sample becomes the new result. The level of the start input at that moment chooses the power mode: if it is high the converter stays awake, and if it is low the converter sleeps until the next rising edge.

The analog part is not modelled. The sample value comes from an input port. Both the power-up window and the conversion time are clock-cycle parameters. Software reads the 10-bit result over an 8-bit bus with an active-low strobe. A byte pointer moves from the upper byte to the lower byte on each strobe. The read port works in every power state.

The controller is a four-state machine:
- SLEEP is the state after reset and means powered down.
- READY means powered up and idle.
- ARMED means the power-up window is running.
- CONVERT means busy.

Its transitions are:
- SLEEP→ARMED and READY→ARMED on a start rising edge (the wake edge).
- ARMED→CONVERT when the window has expired and the start input is low (the hold edge).
- CONVERT→READY when the conversion ends with start high (the stay-awake end).
- CONVERT→SLEEP when the conversion ends with start low (the power-down end).

Top module: `adc_start_seq`

## Requirements
- R1: After reset, busy is 0, the power status is 0 (asleep) and the stored result is 0. A read therefore returns 0.
- R2: Take a start rising edge first seen at clock edge E0, with the start input low again by edge E0+PWRUP_CYC. Busy then goes high right after edge E0+PWRUP_CYC.
- R3: If the start input is still high when the power-up window expires, busy goes high right after the first clock edge at which the start input is seen low.
- R4: Busy stays high for exactly CONV_CYC clock cycles.
- R5: The result is the sample input value taken at the clock edge where busy rises. Later changes to the sample input do not alter it. It becomes readable once busy has fallen.
- R6: If the start input is high at the edge where busy falls, the power status stays 1 (powered up).
- R7: If the start input is low at the edge where busy falls, the power status becomes 0 (powered down).
- R8: A start rising edge that arrives while busy is high, or while the window runs, starts no further conversion.
- R9: The first strobe returns result bits [9:2] on data[7:0]. The next strobe returns result bits [1:0] on data[7:6] with data[5:0] = 0. Further strobes keep alternating. The pointer advances when the strobe (rd_n) goes back high.
- R10: The byte pointer returns to the upper byte whenever a new result is latched.
- R11: Reads return the result while the power status is 0.
- R12: The data output is 0 while rd_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | External convert-start level, synchronous to clk |
| sample_i | input | 10 | Value presented by the analog front end |
| rd_n_i | input | 1 | Active-low read strobe |
| busy_o | output | 1 | High while a conversion is in progress |
| powered_o | output | 1 | 1 = powered up, 0 = powered down |
| data_o | output | 8 | Read data byte |

## Verification
Five vectors drive conversions where the start input is held for different lengths:
- shorter than the power-up window;
- exactly as long as the window;
- longer than the window.

Each vector ends with start either high or low. Together they separate the window-controlled start from the start-controlled start, and the stay-awake end from the power-down end. Sample values with extreme and alternating bit patterns show that the two bytes are split at the right bit positions and that the held value, not the live input, is stored. Directed cases cover the reset state, a rise that lands during busy, and a pointer left on the lower byte when a fresh result arrives.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        ST_SLEEP   = 2'd0,
        ST_READY   = 2'd1,
        ST_ARMED   = 2'd2,
        ST_CONVERT = 2'd3
    } seq_state_t;
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) != '0 && !$past(load_i)) |-> (cnt_q == $past(cnt_q) - 1'b1)); // R4
endmodule

// File: rtl/adc_byte_port.sv
module adc_byte_port #(
    parameter int RES_W = 10,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_n_i,
    input  logic             new_res_i,
    input  logic [RES_W-1:0] result_i,
    output logic [BUS_W-1:0] data_o
);
    localparam int LOW_W = RES_W - BUS_W;
    localparam int PAD_W = BUS_W - LOW_W;

    logic rd_q;
    logic ptr_q;  // 0 = upper byte, 1 = lower byte
    logic strobe_end;

    assign strobe_end = rd_n_i && !rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= 1'b1;
            ptr_q <= 1'b0;
        end else begin
            rd_q <= rd_n_i;
            if (new_res_i) begin
                ptr_q <= 1'b0;
            end else if (strobe_end) begin
                ptr_q <= !ptr_q;
            end
        end
    end

    logic [BUS_W-1:0] upper_byte;
    logic [BUS_W-1:0] lower_byte;

    assign upper_byte = result_i[RES_W-1 -: BUS_W];
    assign lower_byte = {result_i[LOW_W-1:0], {PAD_W{1'b0}}};

    always_comb begin
        if (rd_n_i) begin
            data_o = '0;
        end else if (ptr_q) begin
            data_o = lower_byte;
        end else begin
            data_o = upper_byte;
        end
    end

    AST_PTR_RESET_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        new_res_i |=> !ptr_q); // R10
    AST_PTR_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_end && !new_res_i) |=> (ptr_q != $past(ptr_q))); // R9
endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W     = 10,
    parameter int BUS_W     = 8,
    parameter int PWRUP_CYC = 150,
    parameter int CONV_CYC  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [RES_W-1:0] sample_i,
    input  logic             rd_n_i,
    output logic             busy_o,
    output logic             powered_o,
    output logic [BUS_W-1:0] data_o
);
    localparam int MAX_CYC = (PWRUP_CYC > CONV_CYC) ? PWRUP_CYC : CONV_CYC;
    localparam int TW      = $clog2(MAX_CYC + 1);

    seq_state_t state_q, state_d;

    logic             start_q;
    logic             start_rise;
    logic             pulse_exp;
    logic             conv_exp;
    logic             arm_load;
    logic             conv_load;
    logic             conv_done;
    logic [RES_W-1:0] hold_q;
    logic [RES_W-1:0] result_q;

    assign start_rise = start_i && !start_q;

    seq_timer #(.W(TW)) u_pwrup_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (arm_load),
        .load_val_i (TW'(PWRUP_CYC - 1)),
        .expired_o  (pulse_exp)
    );

    seq_timer #(.W(TW)) u_conv_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (conv_load),
        .load_val_i (TW'(CONV_CYC - 1)),
        .expired_o  (conv_exp)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SLEEP;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and transition strobes
    always_comb begin
        state_d   = state_q;
        arm_load  = 1'b0;
        conv_load = 1'b0;
        conv_done = 1'b0;
        unique case (state_q)
            ST_SLEEP, ST_READY: begin
                if (start_rise) begin
                    arm_load = 1'b1;
                    state_d  = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (pulse_exp && !start_i) begin
                    conv_load = 1'b1;
                    state_d   = ST_CONVERT;
                end
            end
            ST_CONVERT: begin
                if (conv_exp) begin
                    conv_done = 1'b1;
                    state_d   = start_i ? ST_READY : ST_SLEEP;
                end
            end
            default: state_d = ST_SLEEP;
        endcase
    end

    // Outputs
    always_comb begin
        busy_o    = (state_q == ST_CONVERT);
        powered_o = (state_q != ST_SLEEP);
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q  <= 1'b0;
            hold_q   <= '0;
            result_q <= '0;
        end else begin
            start_q <= start_i;
            if (conv_load) begin
                hold_q <= sample_i;
            end
            if (conv_done) begin
                result_q <= hold_q;
            end
        end
    end

    adc_byte_port #(.RES_W(RES_W), .BUS_W(BUS_W)) u_byte_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_n_i    (rd_n_i),
        .new_res_i (conv_done),
        .result_i  (result_q),
        .data_o    (data_o)
    );

    AST_BUSY_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(state_q) == ST_ARMED)); // R2
    AST_BUSY_NEEDS_LOW_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !$past(start_i)); // R3
    AST_STAY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && $past(start_i)) |-> powered_o); // R6
    AST_POWER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && !$past(start_i)) |-> !powered_o); // R7
    AST_NO_REARM_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_rise) |=> (state_q != ST_ARMED)); // R8
    AST_RESULT_STABLE_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(result_q)); // R5
endmodule

// File: tb/adc_start_seq_bench.sv
module adc_start_seq_bench;
    localparam int PW   = 150;
    localparam int CONV = 16;
    localparam int NVEC = 5;

    localparam logic [9:0] VEC_SAMPLE [NVEC] = '{10'h3FF, 10'h001, 10'h2A5, 10'h15A, 10'h200};
    localparam int         VEC_HOLD   [NVEC] = '{3, 150, 200, 1, 160};
    localparam bit         VEC_ENDHI  [NVEC] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [9:0] sample_i = '0;
    logic       rd_n_i = 1'b1;
    logic       busy_o;
    logic       powered_o;
    logic [7:0] data_o;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    adc_start_seq #(.RES_W(10), .BUS_W(8), .PWRUP_CYC(PW), .CONV_CYC(CONV)) u_adc_start_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .sample_i  (sample_i),
        .rd_n_i    (rd_n_i),
        .busy_o    (busy_o),
        .powered_o (powered_o),
        .data_o    (data_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic read_byte(input string req, input int exp);
        rd_n_i = 1'b0;
        #1;
        chk(req, int'(data_o), exp);
        @(negedge clk);
        rd_n_i = 1'b1;
        @(negedge clk);
    endtask

    // Runs one conversion; start held for hold cycles, then set to end_hi during busy.
    task automatic run_conv(input logic [9:0] smp, input int hold, input bit end_hi, input string tag);
        int n;
        int len;
        int exp_rise;
        start_i = 1'b0;
        rd_n_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b1;
        sample_i = smp;
        n = 0;
        exp_rise = ((hold > PW) ? hold : PW) + 1;
        while (n < 2000) begin
            @(negedge clk);
            n++;
            if (busy_o) break;
            if (n == hold) start_i = 1'b0;
        end
        chk((hold > PW) ? {tag, " R3 busy rise cycle"} : {tag, " R2 busy rise cycle"}, n, exp_rise);
        sample_i = ~smp;
        start_i  = end_hi;
        len = 1;
        while (len < 2000) begin
            @(negedge clk);
            if (!busy_o) break;
            len++;
        end
        chk({tag, " R4 busy length"}, len, CONV);
        chk(end_hi ? {tag, " R6 stays powered"} : {tag, " R7 powers down"}, int'(powered_o), int'(end_hi));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy_o), 0);
        chk("R1 power status after reset", int'(powered_o), 0);
        chk("R12 idle bus after reset", int'(data_o), 0);
        read_byte("R1 reset result upper", 0);
        read_byte("R1 reset result lower", 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [9:0] s;
            string tag;
            s = VEC_SAMPLE[i];
            tag = $sformatf("vec%0d", i);
            run_conv(s, VEC_HOLD[i], VEC_ENDHI[i], tag);
            if (VEC_ENDHI[i]) begin
                // start rose during busy: no further conversion may follow (R8)
                repeat (PW + 5) begin
                    @(negedge clk);
                    if (busy_o) break;
                end
                chk({tag, " R8 no conversion from rise during busy"}, int'(busy_o), 0);
            end
            read_byte(VEC_ENDHI[i] ? {tag, " R5 R9 upper byte"} : {tag, " R11 R5 R9 upper byte asleep"},
                      int'(s[9:2]));
            read_byte({tag, " R9 lower byte"}, int'({s[1:0], 6'b0}));
            read_byte({tag, " R9 alternates back to upper"}, int'(s[9:2]));
            #1;
            chk({tag, " R12 bus zero with strobe high"}, int'(data_o), 0);
        end

        // R10: pointer left on lower byte, then new result arrives
        run_conv(10'h0C3, 2, 1'b0, "ptrA");
        read_byte("ptrA R9 upper byte", int'(8'h30));
        run_conv(10'h3C2, 2, 1'b0, "ptrB");
        read_byte("R10 pointer back to upper after new result", int'(8'hF0));
        read_byte("R10 then lower byte", int'(8'h80));

        // R8: rise during power-up window is ignored (no second conversion)
        start_i = 1'b0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        begin
            int busy_cycles;
            busy_cycles = 0;
            repeat (PW + 3 * CONV + 20) begin
                @(negedge clk);
                if (busy_o) busy_cycles++;
            end
            chk("R8 single conversion despite rise in window", busy_cycles, CONV);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule